// File: doc/BRIEF.md
# Partitioned Multi-Mode Multiplier

This block is a two-stage pipelined multiplier for pixel and vector arithmetic. It takes two 32-bit operands and returns one packed 48-bit result. A mode input splits the operands into lanes and selects the product. The choices are one full-width product, two separate half-width products, a complex product, a 2D dot and cross product pair, or four byte-wide products. Each operand has its own signed/unsigned select, so one operation can mix a signed operand with an unsigned one.

A number-type input sets how each product is reduced into its output field. Integer mode keeps the low bits. Fixed-point mode keeps the high bits and can round half-up. Normalised mode treats an all-ones lane as 1.0, so full scale times x returns x exactly. The block accepts a new operation on every cycle. Each result appears two cycles after its input, marked by a valid strobe.

Top module: `part_mul`

## Requirements
- R1: A result is presented with `out_valid` high exactly two clock edges after the edge that sampled `in_valid` high, and `out_valid` is low two edges after `in_valid` low; back-to-back inputs give back-to-back results.
- R2: After reset `result` is zero and `out_valid` is low; while `out_valid` is low, `result` keeps the value of the last presented result.
- R3: Mode 0 (full) forms the 64-bit product P. Integer type (0) returns P[47:0]. Fixed type (1) returns bits 63..16 of P + 2^15 when rounding is on, and of P when it is off.
- R4: Mode 1 (dual) multiplies the upper operand halves into bits 47..24 and the lower halves into bits 23..0. Each 32-bit lane product is reduced to 24 bits: the low 24 bits in integer type, and bits 31..8 of the product plus 2^7 (with rounding on) in fixed type.
- R5: Mode 2 (complex) takes the upper halves as real parts and the lower halves as imaginary parts. It places ar*br - ai*bi in bits 47..24 and ar*bi + ai*br in bits 23..0, each reduced as in R4.
- R6: Mode 3 (vector) takes the upper halves as X and the lower halves as Y. It places the dot product ax*bx + ay*by in bits 47..24 and the cross product ax*by - ay*bx in bits 23..0, each reduced as in R4.
- R7: Mode 4 (quad) multiplies byte lane i of A by byte lane i of B, for i from 0 to 3 with lane 0 at bits 7..0. It puts the result in bits 12i+11..12i, reduced from 16 to 12 bits: the low 12 bits in integer type, and bits 15..4 of the product plus 2^3 (with rounding on) in fixed type.
- R8: `a_signed` and `b_signed` each choose two's-complement or unsigned reading of every lane of their own operand, independently of each other, in integer and fixed types.
- R9: Normalised type (2) in modes 0, 1 and 4 reads both operands as unsigned whatever the sign selects say. Each lane returns floor(P/(2^n-1)), or round-half-up of that quotient when rounding is on, where n is the lane width (32, 16 or 8), zero-extended in its field. An all-ones operand therefore returns the other operand unchanged.
- R10: Normalised type in modes 2 and 3 behaves as fixed type. Type code 3 behaves as integer type.
- R11: Mode codes 5, 6 and 7 return an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| mode | input | 3 | Lane split and product kind (0 full, 1 dual, 2 complex, 3 vector, 4 quad) |
| a_signed | input | 1 | Operand A lanes are two's complement |
| b_signed | input | 1 | Operand B lanes are two's complement |
| num_type | input | 2 | Field reduction: 0 integer, 1 fixed, 2 normalised |
| round_en | input | 1 | Round half-up instead of truncating |
| out_valid | output | 1 | Result present |
| result | output | 48 | Packed result fields |

## Verification
The hardest case to reach is normalised byte mode, where the divide by 255 must be exact at every rounding boundary and at full scale in all four lanes at once. The stimulus covers every (x, y) byte pair with both rounding settings. It packs four consecutive y values into operand B while repeating x in every lane of A. Signed corner values such as 0x8000 and 0x8001 are mixed into the complex and vector sweeps, so the sums of two extreme products exercise wrap-around in both field halves.

// File: rtl/part_mul_pkg.sv
package part_mul_pkg;
  localparam int OPW  = 32;
  localparam int HW   = OPW / 2;
  localparam int QW   = OPW / 4;
  localparam int NQ   = OPW / QW;
  localparam int RESW = OPW + HW;
  localparam int HFW  = RESW / 2;
  localparam int QFW  = RESW / NQ;
  localparam int HPW  = 2 * (HW + 1);
  localparam int QPW  = 2 * (QW + 1);
  localparam int ACCW = 2 * OPW + 2;

  localparam logic [2:0] MODE_FULL = 3'd0;
  localparam logic [2:0] MODE_DUAL = 3'd1;
  localparam logic [2:0] MODE_CPLX = 3'd2;
  localparam logic [2:0] MODE_VEC  = 3'd3;
  localparam logic [2:0] MODE_QUAD = 3'd4;

  localparam logic [1:0] NUM_INT  = 2'd0;
  localparam logic [1:0] NUM_FIX  = 2'd1;
  localparam logic [1:0] NUM_NORM = 2'd2;
  localparam logic [1:0] NUM_RSV  = 2'd3;

  typedef logic signed [ACCW-1:0] acc_t;

  typedef struct packed {
    logic [HPW-1:0]    hh;
    logic [HPW-1:0]    hl;
    logic [HPW-1:0]    lh;
    logic [HPW-1:0]    ll;
    logic [NQ*QPW-1:0] qp;
    logic [2:0]        mode;
    logic [1:0]        ntype;
    logic              rnd;
  } stage1_t;

  // low w bits of v
  function automatic logic [RESW-1:0] keep_low(acc_t v, int w);
    acc_t m;
    m = (acc_t'(1) <<< w) - acc_t'(1);
    return RESW'(v & m);
  endfunction

  // drop s low bits, optional half-up, keep w bits
  function automatic logic [RESW-1:0] keep_high(acc_t v, int s, int w, logic rnd);
    acc_t h;
    acc_t t;
    h = rnd ? (acc_t'(1) <<< (s - 1)) : acc_t'(0);
    t = (v + h) >>> s;
    return keep_low(t, w);
  endfunction

  // v / (2^n - 1) without a divider; v must be non-negative
  function automatic logic [RESW-1:0] div_full_scale(acc_t v, int n, int w, logic rnd);
    acc_t x;
    acc_t y;
    x = v + (rnd ? ((acc_t'(1) <<< (n - 1)) - acc_t'(1)) : acc_t'(0));
    y = (x + acc_t'(1) + (x >>> n)) >>> n;
    return keep_low(y, w);
  endfunction

  // reduce a lane product of two n-bit values into a w-bit field
  function automatic logic [RESW-1:0] reduce_lane(acc_t v, logic [1:0] nt, int n, int w,
                                                  logic rnd);
    logic [RESW-1:0] r;
    case (nt)
      NUM_FIX:  r = keep_high(v, 2 * n - w, w, rnd);
      NUM_NORM: r = div_full_scale(v, n, w, rnd);
      default:  r = keep_low(v, w);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/part_mul_lanes.sv
module part_mul_lanes
  import part_mul_pkg::*;
(
  input  logic [OPW-1:0]    a,
  input  logic [OPW-1:0]    b,
  input  logic [2:0]        mode,
  input  logic              a_sgn,
  input  logic              b_sgn,
  input  logic [1:0]        ntype,
  output logic [HPW-1:0]    hh,
  output logic [HPW-1:0]    hl,
  output logic [HPW-1:0]    lh,
  output logic [HPW-1:0]    ll,
  output logic [NQ*QPW-1:0] qp
);
  logic norm_u;
  logic full;
  logic ea;
  logic eb;
  logic [HW:0] a_hi, a_lo, b_hi, b_lo;
  logic signed [HPW-1:0] p_hh, p_hl, p_lh, p_ll;

  // normalised lanes are always unsigned
  assign norm_u = (ntype == NUM_NORM) &&
                  ((mode == MODE_FULL) || (mode == MODE_DUAL) || (mode == MODE_QUAD));
  assign full = (mode == MODE_FULL);
  assign ea   = a_sgn & ~norm_u;
  assign eb   = b_sgn & ~norm_u;

  // in full mode the low halves are magnitude digits of one wide number
  assign a_hi = {ea & a[OPW-1], a[OPW-1:HW]};
  assign a_lo = {ea & ~full & a[HW-1], a[HW-1:0]};
  assign b_hi = {eb & b[OPW-1], b[OPW-1:HW]};
  assign b_lo = {eb & ~full & b[HW-1], b[HW-1:0]};

  assign p_hh = HPW'($signed(a_hi)) * HPW'($signed(b_hi));
  assign p_hl = HPW'($signed(a_hi)) * HPW'($signed(b_lo));
  assign p_lh = HPW'($signed(a_lo)) * HPW'($signed(b_hi));
  assign p_ll = HPW'($signed(a_lo)) * HPW'($signed(b_lo));

  assign hh = p_hh;
  assign hl = p_hl;
  assign lh = p_lh;
  assign ll = p_ll;

  for (genvar i = 0; i < NQ; i++) begin : g_byte
    logic [QW:0] ax;
    logic [QW:0] bx;
    logic signed [QPW-1:0] pq;
    assign ax = {ea & a[i*QW+QW-1], a[i*QW +: QW]};
    assign bx = {eb & b[i*QW+QW-1], b[i*QW +: QW]};
    assign pq = QPW'($signed(ax)) * QPW'($signed(bx));
    assign qp[i*QPW +: QPW] = pq;
  end
endmodule

// File: rtl/part_mul_pack.sv
module part_mul_pack
  import part_mul_pkg::*;
(
  input  logic [HPW-1:0]    hh,
  input  logic [HPW-1:0]    hl,
  input  logic [HPW-1:0]    lh,
  input  logic [HPW-1:0]    ll,
  input  logic [NQ*QPW-1:0] qp,
  input  logic [2:0]        mode,
  input  logic [1:0]        ntype,
  input  logic              rnd,
  output logic [RESW-1:0]   res
);
  acc_t v_hh, v_hl, v_lh, v_ll;
  acc_t full_p;
  acc_t up_v;
  acc_t lo_v;
  logic pair_mode;
  logic [1:0] nt_eff;
  logic [RESW-1:0] full_res;
  logic [RESW-1:0] half_res;
  logic [RESW-1:0] quad_res;

  assign v_hh = acc_t'($signed(hh));
  assign v_hl = acc_t'($signed(hl));
  assign v_lh = acc_t'($signed(lh));
  assign v_ll = acc_t'($signed(ll));

  assign full_p = (v_hh <<< (2 * HW)) + ((v_hl + v_lh) <<< HW) + v_ll;

  assign pair_mode = (mode == MODE_CPLX) || (mode == MODE_VEC);

  always_comb begin
    nt_eff = ntype;
    if (ntype == NUM_RSV) nt_eff = NUM_INT;
    else if ((ntype == NUM_NORM) && pair_mode) nt_eff = NUM_FIX;
  end

  always_comb begin
    case (mode)
      MODE_CPLX: begin
        up_v = v_hh - v_ll;
        lo_v = v_hl + v_lh;
      end
      MODE_VEC: begin
        up_v = v_hh + v_ll;
        lo_v = v_hl - v_lh;
      end
      default: begin
        up_v = v_hh;
        lo_v = v_ll;
      end
    endcase
  end

  assign full_res = reduce_lane(full_p, nt_eff, OPW, RESW, rnd);
  assign half_res = {HFW'(reduce_lane(up_v, nt_eff, HW, HFW, rnd)),
                     HFW'(reduce_lane(lo_v, nt_eff, HW, HFW, rnd))};

  for (genvar i = 0; i < NQ; i++) begin : g_qf
    acc_t qv;
    assign qv = acc_t'($signed(qp[i*QPW +: QPW]));
    assign quad_res[i*QFW +: QFW] = QFW'(reduce_lane(qv, nt_eff, QW, QFW, rnd));
  end

  always_comb begin
    case (mode)
      MODE_FULL:                       res = full_res;
      MODE_DUAL, MODE_CPLX, MODE_VEC:  res = half_res;
      MODE_QUAD:                       res = quad_res;
      default:                         res = '0;
    endcase
  end
endmodule

// File: rtl/part_mul.sv
module part_mul
  import part_mul_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OPW-1:0]  op_a,
  input  logic [OPW-1:0]  op_b,
  input  logic [2:0]      mode,
  input  logic            a_signed,
  input  logic            b_signed,
  input  logic [1:0]      num_type,
  input  logic            round_en,
  output logic            out_valid,
  output logic [RESW-1:0] result
);
  stage1_t s1_d;
  stage1_t s1_q;
  logic s1_valid;
  logic [2:0] s1_mode;
  logic [HPW-1:0] w_hh, w_hl, w_lh, w_ll;
  logic [NQ*QPW-1:0] w_qp;
  logic [RESW-1:0] res_d;

  part_mul_lanes u_lanes (
    .a     (op_a),
    .b     (op_b),
    .mode  (mode),
    .a_sgn (a_signed),
    .b_sgn (b_signed),
    .ntype (num_type),
    .hh    (w_hh),
    .hl    (w_hl),
    .lh    (w_lh),
    .ll    (w_ll),
    .qp    (w_qp)
  );

  always_comb begin
    s1_d.hh    = w_hh;
    s1_d.hl    = w_hl;
    s1_d.lh    = w_lh;
    s1_d.ll    = w_ll;
    s1_d.qp    = w_qp;
    s1_d.mode  = mode;
    s1_d.ntype = num_type;
    s1_d.rnd   = round_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_q     <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) s1_q <= s1_d;
    end
  end

  assign s1_mode = s1_q.mode;

  part_mul_pack u_pack (
    .hh    (s1_q.hh),
    .hl    (s1_q.hl),
    .lh    (s1_q.lh),
    .ll    (s1_q.ll),
    .qp    (s1_q.qp),
    .mode  (s1_q.mode),
    .ntype (s1_q.ntype),
    .rnd   (s1_q.rnd),
    .res   (res_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) result <= res_d;
    end
  end
endmodule

// File: rtl/part_mul_chk.sv
module part_mul_chk
  import part_mul_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [OPW-1:0]  op_a,
  input logic [OPW-1:0]  op_b,
  input logic [2:0]      mode,
  input logic [1:0]      num_type,
  input logic            s1_valid,
  input logic [2:0]      s1_mode,
  input logic            out_valid,
  input logic [RESW-1:0] result
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_IN_TO_S1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);                                          // R1
  AST_S1_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);                                         // R1
  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);                                       // R1
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(result));                                  // R2
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && (s1_mode > MODE_QUAD)) |=> (result == '0));         // R11
  AST_QUAD_ZERO_B: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst >= 2'd2) && $past(in_valid, 2) && ($past(mode, 2) == MODE_QUAD)
     && ($past(op_b, 2) == '0)) |-> (result == '0));                 // R7
  AST_NORM_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst >= 2'd2) && $past(in_valid, 2) && ($past(mode, 2) == MODE_QUAD)
     && ($past(num_type, 2) == NUM_NORM) && ($past(op_b, 2) == '1))
    |-> (result == {4'h0, $past(op_a[31:24], 2), 4'h0, $past(op_a[23:16], 2),
                    4'h0, $past(op_a[15:8], 2),  4'h0, $past(op_a[7:0], 2)}));  // R9
endmodule

bind part_mul part_mul_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .mode      (mode),
  .num_type  (num_type),
  .s1_valid  (s1_valid),
  .s1_mode   (s1_mode),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/part_mul_tb_top.sv
`timescale 1ns/1ps
module part_mul_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [2:0]  mode = '0;
  logic        a_signed = 1'b0;
  logic        b_signed = 1'b0;
  logic [1:0]  num_type = '0;
  logic        round_en = 1'b0;
  logic        out_valid;
  logic [47:0] result;

  int total = 0;
  int bad = 0;
  int issued = 0;
  bit finished = 1'b0;
  logic [1:0]  vpipe = 2'b00;
  logic [47:0] last_res = '0;
  logic [31:0] seed = 32'h1234_5678;
  logic [47:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  part_mul dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .mode(mode), .a_signed(a_signed), .b_signed(b_signed), .num_type(num_type),
    .round_en(round_en), .out_valid(out_valid), .result(result)
  );

  function automatic logic signed [127:0] sx(logic [31:0] v, int w, logic s);
    logic signed [127:0] r;
    r = '0;
    for (int i = 0; i < w; i++) r[i] = v[i];
    if (s && v[w-1]) r = r - (128'sd1 <<< w);
    return r;
  endfunction

  function automatic logic [47:0] conv(logic signed [127:0] val, int n, int w, int et,
                                       logic r);
    logic signed [127:0] t;
    logic signed [127:0] d;
    logic signed [127:0] one;
    int s;
    one = 128'sd1;
    s = 2 * n - w;
    if (et == 1) t = (val + (r ? (one <<< (s - 1)) : 128'sd0)) >>> s;
    else if (et == 2) begin
      d = (one <<< n) - one;
      t = r ? (2 * val + d) / (2 * d) : val / d;
    end else t = val;
    t = t & ((one <<< w) - one);
    return t[47:0];
  endfunction

  function automatic logic [47:0] model(logic [31:0] a, logic [31:0] b, logic [2:0] m,
                                        logic as, logic bs, logic [1:0] nt, logic r);
    logic nok;
    logic sa, sb;
    int et;
    logic signed [127:0] ax, ay, bx, by, up, lo;
    logic [47:0] o, t1, t2;
    if (m > 3'd4) return '0;
    nok = (nt == 2'd2) && (m == 3'd0 || m == 3'd1 || m == 3'd4);
    et  = (nt == 2'd3) ? 0 : ((nt == 2'd2) && !nok) ? 1 : int'(nt);
    sa  = as & !nok;
    sb  = bs & !nok;
    o = '0;
    if (m == 3'd0) begin
      o = conv(sx(a, 32, sa) * sx(b, 32, sb), 32, 48, et, r);
    end else if (m == 3'd4) begin
      for (int i = 0; i < 4; i++) begin
        t1 = conv(sx(a >> (8 * i), 8, sa) * sx(b >> (8 * i), 8, sb), 8, 12, et, r);
        o[12*i +: 12] = t1[11:0];
      end
    end else begin
      ax = sx(a >> 16, 16, sa); ay = sx(a, 16, sa);
      bx = sx(b >> 16, 16, sb); by = sx(b, 16, sb);
      if (m == 3'd1)      begin up = ax * bx;           lo = ay * by;           end
      else if (m == 3'd2) begin up = ax * bx - ay * by; lo = ax * by + ay * bx; end
      else                begin up = ax * bx + ay * by; lo = ax * by - ay * bx; end
      t1 = conv(up, 16, 24, et, r);
      t2 = conv(lo, 16, 24, et, r);
      o = {t1[23:0], t2[23:0]};
    end
    return o;
  endfunction

  function automatic string tagof(logic [2:0] m, logic as, logic bs, logic [1:0] nt);
    if (m > 3'd4) return "R11";
    if (nt == 2'd2 && (m == 3'd0 || m == 3'd1 || m == 3'd4)) return "R9";
    if (nt == 2'd2 || nt == 2'd3) return "R10";
    if (as || bs) return "R8";
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [15:0] corner(logic [2:0] k);
    case (k)
      3'd0: return 16'h0000;
      3'd1: return 16'h0001;
      3'd2: return 16'h7FFF;
      3'd3: return 16'h8000;
      3'd4: return 16'hFFFF;
      3'd5: return 16'h00FF;
      3'd6: return 16'h8001;
      default: return 16'hFF00;
    endcase
  endfunction

  task automatic next_word(output logic [31:0] v);
    logic [15:0] h [2];
    for (int i = 0; i < 2; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      h[i] = (seed[3:2] == 2'b00) ? corner(seed[6:4]) : seed[31:16];
    end
    v = {h[1], h[0]};
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input logic [2:0] m, input logic as, input logic bs,
                      input logic [1:0] nt, input logic r);
    logic [47:0] e;
    string t;
    @(negedge clk);
    total++;
    if (out_valid !== vpipe[1]) begin
      bad++;
      $display("FAIL R1 out_valid got=%b exp=%b", out_valid, vpipe[1]);
    end
    if (out_valid === 1'b1 && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (result !== e) begin
        bad++;
        $display("FAIL %s result got=%h exp=%h", t, result, e);
      end
      last_res = result;
    end else if (out_valid !== 1'b1) begin
      total++;
      if (result !== last_res) begin
        bad++;
        $display("FAIL R2 held result got=%h exp=%h", result, last_res);
      end
    end
    vpipe = {vpipe[0], v};
    in_valid = v; op_a = a; op_b = b; mode = m;
    a_signed = as; b_signed = bs; num_type = nt; round_en = r;
    if (v) begin
      exp_q.push_back(model(a, b, m, as, bs, nt, r));
      tag_q.push_back(tagof(m, as, bs, nt));
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [2:0] m,
                       input logic as, input logic bs, input logic [1:0] nt, input logic r);
    step(1'b1, a, b, m, as, bs, nt, r);
    issued++;
    if (issued % 11 == 0) step(1'b0, 32'hDEAD_BEEF, 32'h0BAD_F00D, m, as, bs, nt, r);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired got=running exp=done");
    summary();
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (result !== '0 || out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R2 reset got=%h/%b exp=0/0", result, out_valid);
    end
    rst_n = 1'b1;

    // every byte pair, normalised, both rounding settings
    for (int r = 0; r < 2; r++)
      for (int x = 0; x < 256; x++)
        for (int g = 0; g < 64; g++) begin
          b = {8'(g*4+3), 8'(g*4+2), 8'(g*4+1), 8'(g*4)};
          issue({4{8'(x)}}, b, 3'd4, 1'b0, 1'b0, 2'd2, 1'(r));
        end

    // byte lanes, integer and fixed, all sign combinations
    for (int nt = 0; nt < 2; nt++)
      for (int r = 0; r < 2; r++)
        for (int s = 0; s < 4; s++)
          for (int k = 0; k < 256; k++) begin
            next_word(a);
            next_word(b);
            issue(a, b, 3'd4, 1'(s >> 1), 1'(s), 2'(nt), 1'(r));
          end

    // wide, dual, complex and vector modes over all types and signs
    for (int m = 0; m < 4; m++)
      for (int nt = 0; nt < 4; nt++)
        for (int r = 0; r < 2; r++)
          for (int s = 0; s < 4; s++)
            for (int k = 0; k < 40; k++) begin
              next_word(a);
              next_word(b);
              issue(a, b, 3'(m), 1'(s >> 1), 1'(s), 2'(nt), 1'(r));
            end

    // full-scale identity in the wide lanes
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 128; k++) begin
        next_word(a);
        issue(a, 32'hFFFF_FFFF, 3'(m), 1'b1, 1'b1, 2'd2, 1'(k));
      end

    // reserved mode codes
    for (int m = 5; m < 8; m++)
      for (int k = 0; k < 20; k++) begin
        next_word(a);
        next_word(b);
        issue(a, b, 3'(m), 1'(k), 1'(k >> 1), 2'(k), 1'(k >> 2));
      end

    for (int k = 0; k < 4; k++) step(1'b0, '0, '0, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0);
    summary();
  end
endmodule